// File: doc/BRIEF.md
# Sound Command List Sequencer

The sequencer runs three independent command streams held in memory and turns them into writes to the registers of a sound generator. On every horizontal-retrace strobe each enabled channel that is not pausing reads one 16-bit command word from its own source address. Once all three slots have been offered, the fetched commands are carried out one after another, channel 0 first.

The command set covers register loads, pauses counted in prescaled ticks, and a single-level repeat/loop construct. A control group of flag bits requests a CPU interrupt, closes a loop or halts the stream, and the flags can be combined in one word. Register loads take several cycles and stretch when the CPU holds the peripheral bus. The host sets each source address through a write strobe and reaches the enable and interrupt bits through one status byte. An active-low interrupt line summarises the pending requests.

Top module: `snd_list_seq`

## Requirements
- R1: On each `hsync` pulse, every channel whose enable bit is set and whose pause count is zero reads one word at its source address (`mem_rd` high, `mem_addr` even). `mem_rdata[7:0]` is the byte at `mem_addr` and `mem_rdata[15:8]` is the byte at `mem_addr+1`. The source address then advances by 2. A source written through `src_we` has bit 0 forced to 0. A disabled channel performs no read.
- R2: Commands fetched on one retrace are executed after all three fetch slots, in the order channel 0, 1, 2.
- R3: A word of the form 0RDDh (bits 15..12 = 0) is a load. In its last cycle it pulses `snd_we` for one cycle with `snd_reg` = R (bits 11..8) and `snd_data` = DD (bits 7..0).
- R4: A load occupies 8 cycles, or 9 if `cpu_busy` is high in its first cycle, or 10 if `cpu_psg_wr` is high then. Every other command takes 1 cycle. Loads of consecutive channels therefore produce `snd_we` pulses that many cycles apart.
- R5: 2NNNh (N > 0) sets the channel's loop counter to N and marks the following word as loop start. Control bit 0 of a 4xxxh word (loop) jumps back to that mark and decrements the counter when the counter is nonzero, and otherwise falls through. The loop body runs N+1 times.
- R6: 2000h, 1000h, 4000h and every 3xxxh word have no effect other than using up the channel's slot. In particular, 2000h leaves an active loop untouched.
- R7: 1NNNh (N > 0) loads a pause count. While the count is nonzero the channel skips its fetches. Each `tick` pulse lowers the count by one, and fetching resumes on the first retrace after it reaches zero.
- R8: In a 4xxxh word, bit 0 is loop, bit 4 is interrupt and bit 5 is stop. Any combination of these bits acts together, for example 4030h interrupts and stops.
- R9: Stop clears the channel's enable bit and leaves the source address on the next word, so re-enabling continues the stream there.
- R10: `stat_rd` bits 2..0 are the channel enables, which a `stat_we` write loads from `stat_wdata[2:0]`. Bits 6..4 read 0 while channel 0, 1 or 2 has an interrupt pending, and writing 1 to such a bit clears that request. Bit 3 reads 0 and bit 7 reads 1.
- R11: `irq_n` is the AND of `stat_rd` bits 7..4, so it is low while any channel has a request pending.
- R12: After reset, all channels are disabled, no interrupt is pending, `stat_rd` = F0h, `irq_n` = 1 and `snd_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | One-cycle horizontal-retrace strobe |
| tick | input | 1 | One-cycle prescaled pause tick |
| cpu_busy | input | 1 | CPU is accessing the peripheral port |
| cpu_psg_wr | input | 1 | That CPU access is a sound-register write |
| mem_rd | output | 1 | Command read request |
| mem_addr | output | AW | Byte address of the command word |
| mem_rdata | input | 16 | Command word, low byte from the lower address |
| src_we | input | NCH | Per-channel source address write strobe |
| src_wdata | input | AW | Source address write value |
| stat_we | input | 1 | Status byte write strobe |
| stat_wdata | input | 8 | Status byte write value |
| stat_rd | output | 8 | Status byte: enables and active-low interrupt bits |
| irq_n | output | 1 | Combined active-low interrupt |
| snd_we | output | 1 | Sound-register write strobe |
| snd_reg | output | 4 | Sound-register number |
| snd_data | output | 8 | Sound-register data |

## Verification
Random enable masks with random load words on all three channels show whether the fetch gating and the channel execution order are right, because a wrong order or a leaked disabled channel changes the sequence of logged writes. Back-to-back loads under three CPU bus conditions measure the spacing of `snd_we` pulses, which separates the 8, 9 and 10 cycle cases. Random repeat counts from 0 to 4, together with a program that places a zero repeat inside a live loop, count the writes per loop and catch an off-by-one or a zero repeat that wrongly moves the mark. Directed pause, reserved-opcode and combined-control programs, read back through `stat_rd`, `irq_n` and later writes, tell ignored words apart from words that act.

// File: rtl/snd_seq_pkg.sv
// Package: shared command types and the decoder for the sound list sequencer.
// Assumes 16-bit command words with the opcode in bits 15..12.
package snd_seq_pkg;

    localparam int ARG_W = 12;

    typedef enum logic [2:0] {
        K_NOP,
        K_LOAD,
        K_PAUSE,
        K_REPEAT,
        K_CTRL
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [ARG_W-1:0] arg;
        logic             f_loop;
        logic             f_int;
        logic             f_stop;
    } insn_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FETCH,
        PH_EXEC
    } phase_e;

    // Turns a raw word into a command; zero-argument and unknown words become NOP.
    function automatic insn_t decode_word(input logic [15:0] w);
        insn_t d;
        d.kind   = K_NOP;
        d.arg    = w[11:0];
        d.f_loop = 1'b0;
        d.f_int  = 1'b0;
        d.f_stop = 1'b0;
        case (w[15:12])
            4'h0: d.kind = K_LOAD;
            4'h1: d.kind = (w[11:0] != 12'd0) ? K_PAUSE : K_NOP;
            4'h2: d.kind = (w[11:0] != 12'd0) ? K_REPEAT : K_NOP;
            4'h4: begin
                d.f_loop = w[0];
                d.f_int  = w[4];
                d.f_stop = w[5];
                d.kind   = (w[0] | w[4] | w[5]) ? K_CTRL : K_NOP;
            end
            default: d.kind = K_NOP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/snd_seq_chan.sv
// Module: one command stream. It holds the source address, the fetched word,
// the loop mark and counter, and the pause counter. It assumes the
// controller never raises fetch_slot and exec_go in the same cycle.
module snd_seq_chan
    import snd_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          fetch_slot,
    input  logic [15:0]   rdata,
    input  logic          exec_go,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    output logic          mem_req,
    output logic [AW-1:0] src,
    output logic          valid,
    output insn_t         insn
);

    logic [15:0]      word_q;
    logic [AW-1:0]    loop_q;
    logic [ARG_W-1:0] loop_cnt;
    logic [ARG_W-1:0] pause_cnt;
    logic             take_loop;

    // Fetch is granted only in this channel's slot, when enabled and not pausing.
    assign mem_req   = fetch_slot && en && (pause_cnt == '0);
    assign insn      = decode_word(word_q);
    assign take_loop = exec_go && (insn.kind == K_CTRL) && insn.f_loop && (loop_cnt != '0);

    // Capture the fetched word and whether this slot produced one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            valid  <= 1'b0;
        end else if (fetch_slot) begin
            valid <= mem_req;
            if (mem_req) word_q <= rdata;
        end
    end

    // Source address: host write, loop jump or post-fetch advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         src <= '0;
        else if (addr_we)   src <= {addr_wdata[AW-1:1], 1'b0};
        else if (take_loop) src <= loop_q;
        else if (mem_req)   src <= src + AW'(2);
    end

    // Loop mark and counter, set by repeat and spent by loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_q   <= '0;
            loop_cnt <= '0;
        end else if (exec_go && insn.kind == K_REPEAT) begin
            loop_q   <= src;
            loop_cnt <= insn.arg;
        end else if (take_loop) begin
            loop_cnt <= loop_cnt - 1'b1;
        end
    end

    // Pause counter, loaded by pause and lowered by prescaled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                                pause_cnt <= '0;
        else if (exec_go && insn.kind == K_PAUSE)  pause_cnt <= insn.arg;
        else if (tick && pause_cnt != '0)          pause_cnt <= pause_cnt - 1'b1;
    end

endmodule

// File: rtl/snd_seq_ctrl.sv
// Module: line sequencer. After a retrace strobe it offers one fetch slot per
// channel, then executes the channels in index order. Loads hold a channel
// for LOAD_CYC cycles plus the bus-contention extra sampled in their first
// cycle. Strobes that arrive while a line is in progress are dropped.
module snd_seq_ctrl
    import snd_seq_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int LOAD_CYC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync,
    input  logic [NCH-1:0] valid,
    input  logic [NCH-1:0] is_load,
    input  logic           cpu_busy,
    input  logic           cpu_psg_wr,
    output logic [NCH-1:0] fetch_slot,
    output logic [NCH-1:0] exec_go
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int TW = $clog2(LOAD_CYC + 2) + 1;

    phase_e          ph;
    logic [IW-1:0]   idx;
    logic            load_run;
    logic [TW-1:0]   tmr;
    logic            cur_valid;
    logic            cur_load;
    logic            step;
    logic            commit;
    logic [1:0]      extra;

    assign cur_valid = valid[idx];
    assign cur_load  = is_load[idx];
    assign extra     = cpu_psg_wr ? 2'd2 : (cpu_busy ? 2'd1 : 2'd0);
    assign step      = (ph == PH_EXEC) && (!cur_valid || !cur_load || (load_run && tmr == '0));
    assign commit    = step && cur_valid;

    // Decode the current slot into one-hot fetch and execute strobes.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            fetch_slot[i] = (ph == PH_FETCH) && (idx == IW'(i));
            exec_go[i]    = commit && (idx == IW'(i));
        end
    end

    // Phase and slot index progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            idx <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (hsync) begin
                    ph  <= PH_FETCH;
                    idx <= '0;
                end
                PH_FETCH: begin
                    if (idx == IW'(NCH - 1)) begin
                        ph  <= PH_EXEC;
                        idx <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_EXEC: if (step) begin
                    if (idx == IW'(NCH - 1)) ph <= PH_IDLE;
                    else                     idx <= idx + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Multi-cycle load timer, armed on the first cycle of a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_run <= 1'b0;
            tmr      <= '0;
        end else if (step) begin
            load_run <= 1'b0;
        end else if (ph == PH_EXEC && cur_valid && cur_load && !load_run) begin
            load_run <= 1'b1;
            tmr      <= TW'(LOAD_CYC - 2) + TW'(extra);
        end else if (load_run) begin
            tmr <= tmr - 1'b1;
        end
    end

endmodule

// File: rtl/snd_seq_stat.sv
// Module: status byte. It holds the channel enables and the pending
// interrupt flags and forms the active-low combined interrupt. A command's
// stop or interrupt wins over a host write in the same cycle. The bit
// layout assumes at most three channels.
module snd_seq_stat #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stat_we,
    input  logic [7:0]     stat_wdata,
    input  logic [NCH-1:0] stop_hit,
    input  logic [NCH-1:0] int_hit,
    output logic [NCH-1:0] en,
    output logic [7:0]     stat_rd,
    output logic           irq_n
);

    logic [NCH-1:0] pend;
    logic           unused_wbits;

    assign unused_wbits = ^stat_wdata;
    assign irq_n        = ~|pend;

    // Enable bits: set or cleared by the host, cleared by stop.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n)           en[i] <= 1'b0;
            else if (stop_hit[i]) en[i] <= 1'b0;
            else if (stat_we)     en[i] <= stat_wdata[i];
        end
    end

    // Interrupt flags: raised by commands, dropped by a host write of 1.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n)                             pend[i] <= 1'b0;
            else if (int_hit[i])                    pend[i] <= 1'b1;
            else if (stat_we && stat_wdata[4 + i])  pend[i] <= 1'b0;
        end
    end

    // Assemble the readable status byte.
    always_comb begin
        stat_rd = 8'h80;
        for (int i = 0; i < NCH; i++) begin
            stat_rd[i]     = en[i];
            stat_rd[4 + i] = ~pend[i];
        end
        for (int i = NCH; i < 3; i++) stat_rd[4 + i] = 1'b1;
    end

endmodule

// File: rtl/snd_list_seq.sv
// Module: top of the sound command list sequencer. It ties NCH command
// streams to the line sequencer, the status byte, the shared command read
// port and the sound-register write port. It assumes the memory returns
// the word combinationally in the cycle of the request.
module snd_list_seq
    import snd_seq_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int AW       = 16,
    parameter int LOAD_CYC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync,
    input  logic           tick,
    input  logic           cpu_busy,
    input  logic           cpu_psg_wr,
    output logic           mem_rd,
    output logic [AW-1:0]  mem_addr,
    input  logic [15:0]    mem_rdata,
    input  logic [NCH-1:0] src_we,
    input  logic [AW-1:0]  src_wdata,
    input  logic           stat_we,
    input  logic [7:0]     stat_wdata,
    output logic [7:0]     stat_rd,
    output logic           irq_n,
    output logic           snd_we,
    output logic [3:0]     snd_reg,
    output logic [7:0]     snd_data
);

    logic [NCH-1:0] fetch_slot;
    logic [NCH-1:0] exec_go;
    logic [NCH-1:0] mem_req;
    logic [NCH-1:0] valid;
    logic [NCH-1:0] is_load;
    logic [NCH-1:0] stop_hit;
    logic [NCH-1:0] int_hit;
    logic [NCH-1:0] en;
    logic [AW-1:0]  src_a [NCH];
    insn_t          insn_a [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        snd_seq_chan #(.AW(AW)) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .en         (en[g]),
            .fetch_slot (fetch_slot[g]),
            .rdata      (mem_rdata),
            .exec_go    (exec_go[g]),
            .addr_we    (src_we[g]),
            .addr_wdata (src_wdata),
            .mem_req    (mem_req[g]),
            .src        (src_a[g]),
            .valid      (valid[g]),
            .insn       (insn_a[g])
        );
        assign is_load[g]  = insn_a[g].kind == K_LOAD;
        assign stop_hit[g] = exec_go[g] && insn_a[g].kind == K_CTRL && insn_a[g].f_stop;
        assign int_hit[g]  = exec_go[g] && insn_a[g].kind == K_CTRL && insn_a[g].f_int;
    end

    snd_seq_ctrl #(.NCH(NCH), .LOAD_CYC(LOAD_CYC)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .valid      (valid),
        .is_load    (is_load),
        .cpu_busy   (cpu_busy),
        .cpu_psg_wr (cpu_psg_wr),
        .fetch_slot (fetch_slot),
        .exec_go    (exec_go)
    );

    snd_seq_stat #(.NCH(NCH)) i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .stop_hit   (stop_hit),
        .int_hit    (int_hit),
        .en         (en),
        .stat_rd    (stat_rd),
        .irq_n      (irq_n)
    );

    // Route the requesting channel's address to the read port.
    always_comb begin
        mem_rd   = |mem_req;
        mem_addr = '0;
        for (int i = 0; i < NCH; i++) if (mem_req[i]) mem_addr = src_a[i];
    end

    // Route the completing load to the sound-register write port.
    always_comb begin
        snd_we   = 1'b0;
        snd_reg  = '0;
        snd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (exec_go[i] && insn_a[i].kind == K_LOAD) begin
                snd_we   = 1'b1;
                snd_reg  = insn_a[i].arg[11:8];
                snd_data = insn_a[i].arg[7:0];
            end
        end
    end

endmodule

// File: rtl/snd_seq_chk.sv
// Module: port-level property checker for the sequencer, attached by bind.
module snd_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          stat_we,
    input logic [7:0]    stat_rd,
    input logic          irq_n,
    input logic          snd_we
);

    a_r1_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !mem_addr[0]);

    a_r1_fetch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (stat_rd[2:0] != 3'b000));

    a_r4_loads_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        snd_we |=> !snd_we);

    a_r10_enable_from_host: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rd[2:0] & ~$past(stat_rd[2:0])) != 3'b000) |-> $past(stat_we));

    a_r11_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd[6:4] != 3'b111) |-> !irq_n);

    a_r11_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd[7:4] == 4'hF) |-> irq_n);

endmodule

bind snd_list_seq snd_seq_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .stat_we  (stat_we),
    .stat_rd  (stat_rd),
    .irq_n    (irq_n),
    .snd_we   (snd_we)
);

// File: tb/test_snd_list_seq.sv
// Bench: directed programs plus seeded random loads and repeat counts.
module test_snd_list_seq;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0, tick = 1'b0, cpu_busy = 1'b0, cpu_psg_wr = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr, mem_rdata;
    logic [2:0]  src_we = 3'b000;
    logic [15:0] src_wdata = 16'h0;
    logic        stat_we = 1'b0;
    logic [7:0]  stat_wdata = 8'h0;
    logic [7:0]  stat_rd;
    logic        irq_n, snd_we;
    logic [3:0]  snd_reg;
    logic [7:0]  snd_data;

    logic [7:0]  mem [0:511];
    int          nchk = 0, nerr = 0, cyc = 0, rd_n = 0, wr_n = 0;
    int          wr_reg [64];
    int          wr_dat [64];
    int          wr_cyc [64];
    bit          done = 1'b0;

    assign mem_rdata = {mem[9'(mem_addr + 16'd1)], mem[9'(mem_addr)]};

    always #(CLK_P / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    snd_list_seq i_snd_list_seq (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .tick(tick),
        .cpu_busy(cpu_busy), .cpu_psg_wr(cpu_psg_wr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .src_we(src_we), .src_wdata(src_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rd(stat_rd), .irq_n(irq_n),
        .snd_we(snd_we), .snd_reg(snd_reg), .snd_data(snd_data)
    );

    // Log reads and sound writes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && mem_rd) rd_n++;
        if (rst_n && snd_we && wr_n < 64) begin
            wr_reg[wr_n] = int'(snd_reg);
            wr_dat[wr_n] = int'(snd_data);
            wr_cyc[wr_n] = cyc;
            wr_n++;
        end
    end

    function automatic int popcnt3(input int m);
        return (m & 1) + ((m >> 1) & 1) + ((m >> 2) & 1);
    endfunction

    function automatic int loop_writes(input int n);
        return n + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr_n = 0; rd_n = 0;
    endtask

    task automatic put(input int a, input logic [15:0] w);
        mem[a]     = w[7:0];
        mem[a + 1] = w[15:8];
    endtask

    task automatic setsrc(input int ch, input int a);
        @(negedge clk); src_we = 3'(1 << ch); src_wdata = 16'(a);
        @(negedge clk); src_we = 3'b000;
    endtask

    task automatic wstat(input int v);
        @(negedge clk); stat_we = 1'b1; stat_wdata = 8'(v);
        @(negedge clk); stat_we = 1'b0;
    endtask

    task automatic line(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); hsync = 1'b1;
            @(negedge clk); hsync = 1'b0;
            repeat (45) @(negedge clk);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) mem[i] = 8'h40;
        do_reset();
        // R12 reset state
        chk("R12 stat", int'(stat_rd), 'hF0);
        chk("R12 irq_n", int'(irq_n), 1);
        chk("R12 snd_we", int'(snd_we), 0);

        // R1 R3: little-endian fetch, odd source forced even, disabled channels silent
        put('h100, 16'h035A);
        setsrc(0, 'h101); wstat(1); rd_n = 0; line(1);
        chk("R1 read count", rd_n, 1);
        chk("R3 write count", wr_n, 1);
        chk("R3 reg", wr_reg[0], 3);
        chk("R3 data", wr_dat[0], 'h5A);

        // R2 R4 R1: channel order, load spacing, address advance
        do_reset();
        put('h100, 16'h0111); put('h102, 16'h0555); put('h104, 16'h0888);
        put('h120, 16'h0222); put('h122, 16'h0666); put('h124, 16'h0999);
        put('h140, 16'h0444); put('h142, 16'h0777); put('h144, 16'h0AAA);
        setsrc(0, 'h100); setsrc(1, 'h120); setsrc(2, 'h140); wstat(7);
        line(1);
        chk("R2 count", wr_n, 3);
        chk("R2 first", wr_reg[0], 1);
        chk("R2 second", wr_reg[1], 2);
        chk("R2 third", wr_reg[2], 4);
        chk("R4 spacing idle", wr_cyc[2] - wr_cyc[1], 8);
        wr_n = 0; cpu_busy = 1'b1; line(1);
        chk("R1 advance", wr_reg[0], 5);
        chk("R4 spacing busy", wr_cyc[2] - wr_cyc[1], 9);
        wr_n = 0; cpu_psg_wr = 1'b1; line(1);
        chk("R4 spacing psg write", wr_cyc[2] - wr_cyc[1], 10);
        cpu_busy = 1'b0; cpu_psg_wr = 1'b0;

        // R5 R9: repeat 2 runs the body three times, then stop clears enable
        do_reset();
        put('h100, 16'h2002); put('h102, 16'h0701); put('h104, 16'h4001); put('h106, 16'h4020);
        setsrc(0, 'h100); wstat(1); line(10);
        chk("R5 body runs", wr_n, 3);
        chk("R9 enable cleared", int'(stat_rd[2:0]), 0);

        // R6: a zero repeat inside a live loop must not move the mark
        do_reset();
        put('h100, 16'h2001); put('h102, 16'h0811); put('h104, 16'h2000);
        put('h106, 16'h0922); put('h108, 16'h4001); put('h10A, 16'h4020);
        setsrc(0, 'h100); wstat(1); line(12);
        chk("R6 zero repeat count", wr_n, 4);
        chk("R6 order", wr_reg[2], 8);
        chk("R6 order last", wr_reg[3], 9);

        // R7: pause 3 holds fetches until three ticks
        do_reset();
        put('h100, 16'h1003); put('h102, 16'h0A33);
        setsrc(0, 'h100); wstat(1); line(1);
        rd_n = 0; line(2);
        chk("R7 no fetch while paused", rd_n, 0);
        pulse_tick(); pulse_tick(); line(1);
        chk("R7 still paused", wr_n, 0);
        pulse_tick(); line(1);
        chk("R7 resumed", wr_n, 1);

        // R6: pause 0, reserved word and plain control word do nothing
        do_reset();
        put('h100, 16'h1000); put('h102, 16'h3ABC); put('h104, 16'h4000); put('h106, 16'h0B44);
        setsrc(0, 'h100); wstat(1); line(3);
        chk("R6 no effect words", wr_n, 0);
        line(1);
        chk("R6 next load", wr_reg[0], 'hB);

        // R8 R9 R10 R11: combined interrupt+stop, host clears, resume
        do_reset();
        put('h100, 16'h4030); put('h102, 16'h0C55);
        put('h120, 16'h4010); put('h122, 16'h4020);
        setsrc(0, 'h100); setsrc(1, 'h120); wstat(3); line(1);
        chk("R8 int and stop", int'(stat_rd), 'hC2);
        chk("R11 irq low", int'(irq_n), 0);
        wstat('h12);
        chk("R10 write one clears", int'(stat_rd), 'hD2);
        chk("R11 one still pending", int'(irq_n), 0);
        wstat('h22);
        chk("R11 irq released", int'(irq_n), 1);
        wstat('h03); line(1);
        chk("R9 resumed stream", wr_n, 1);
        chk("R9 resumed reg", wr_reg[0], 'hC);
        chk("R10 after stop", int'(stat_rd), 'hF1);

        // R1 R2 R3: random masks and load words
        for (int it = 0; it < 12; it++) begin
            int m;
            logic [15:0] w [3];
            do_reset();
            m = int'($urandom % 8);
            for (int c = 0; c < 3; c++) begin
                w[c] = {4'h0, 12'($urandom)};
                put('h100 + 'h20 * c, w[c]);
                setsrc(c, 'h100 + 'h20 * c);
            end
            wstat(m); line(1);
            chk("R2 random count", wr_n, popcnt3(m));
            begin
                int k = 0;
                for (int c = 0; c < 3; c++) begin
                    if (((m >> c) & 1) == 1 && k < wr_n) begin
                        chk("R3 random reg", wr_reg[k], int'(w[c][11:8]));
                        chk("R3 random data", wr_dat[k], int'(w[c][7:0]));
                        k++;
                    end
                end
            end
        end

        // R5: random repeat counts
        for (int it = 0; it < 8; it++) begin
            int n;
            do_reset();
            n = int'($urandom % 5);
            put('h180, 16'h2000 | 16'(n)); put('h182, 16'h0E00 | 16'(it));
            put('h184, 16'h4001); put('h186, 16'h4020);
            setsrc(0, 'h180); wstat(1); line(2 * (n + 1) + 3);
            chk("R5 random repeat", wr_n, loop_writes(n));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule